// File: doc/BRIEF.md
# Cache-Disabled Range Update Sequencer

This block applies a new set of memory-range attribute registers without letting a partly updated configuration ever take effect. On a start request it drives the cache into a no-fill mode and has the caches written back and invalidated. It turns global pages off and flushes the TLB. It then saves the default-type register and writes it with ranges disabled and the default type set to uncacheable. Only after all of that does it walk the range register file. Each register is compared with its target value under a per-kind significance mask, and the target is written only where a significant bit differs. The default-type change is folded into the saved copy. The exit path flushes the TLB and restores the saved default type, then re-enables the cache and restores global pages, in that order.

The register file is reached through one address bus with two combinational read returns: the hardware value (`reg_rdata_i`) and the desired value (`tgt_rdata_i`). There is also a single write strobe. The cache flush and the TLB flush are level request / done handshakes. Completion is a one-cycle `done_o` together with a three-bit change mask.

States: IDLE, CD_ON, WBINV, PGE_OFF, TLB_IN, DEF_SAVE, DEF_CLR, SCAN, DEF_CMP, TLB_OUT, DEF_REST, CD_OFF, PGE_ON, DONE. Transitions:
- IDLE moves to CD_ON on `start_i`.
- CD_ON moves to WBINV.
- WBINV moves to PGE_OFF when the flush done is seen.
- PGE_OFF moves to TLB_IN.
- TLB_IN moves to DEF_SAVE when the TLB done is seen.
- DEF_SAVE moves to DEF_CLR, and DEF_CLR moves to SCAN.
- SCAN moves to DEF_CMP after its last register.
- DEF_CMP moves to TLB_OUT.
- TLB_OUT moves to DEF_REST when the TLB done is seen.
- DEF_REST moves to CD_OFF, CD_OFF to PGE_ON, PGE_ON to DONE, and DONE back to IDLE.

Top module: `rus_top`

## Requirements
- R1: After reset `busy_o`, `cd_o`, `nw_o`, `done_o`, `reg_we_o` and both flush requests are 0. A start is taken only in IDLE, and `start_i` while busy has no effect: exactly one `done_o` results and the event order is unchanged.
- R2: On start, `cd_o` rises first with `nw_o` held 0. Then `wb_req_o` is raised and held until `wb_done_i`, and no later step begins before that done.
- R3: After the write-back completes, the current global-page state is saved and `pge_o` is cleared no later than the cycle in which `tlb_req_o` is raised.
- R4: Register layout: address 0 is default-type, variable slot i has its base at 2i+1 and its mask at 2i+2, and the 11 fixed words follow from 2·NVAR+1. After the TLB flush, address 0 is read, saved, and written with bits 11:10 and 7:0 cleared, all other bits kept.
- R5: Slots are visited in ascending order, mask before base. A base is compared on low bits under 0xFFFFF0FF and a mask under 0xFFFFF800, and both high words under `PA_HI_MASK`. A register is written only if these bits differ, and only while `cd_o`=1 and `pge_o`=0.
- R6: A slot whose target mask has bit 11 clear is disabled: its desired mask and base are both all-zero.
- R7: The fixed words are compared on all 64 bits and visited in address order: one 64K word, two 16K words, then eight 4K words.
- R8: If bits 11:10 or 7:0 of the saved default-type differ from the target, those bits of the saved copy are replaced by the target's and all other saved bits are kept.
- R9: On exit the order is: TLB flush (no cache flush), write of the saved default-type to address 0, `cd_o` cleared, then `pge_o` restored to its saved value.
- R10: `done_o` is high for exactly one cycle after `pge_o` is restored. `chg_o` then holds bit 0 = a variable register was written, bit 1 = a fixed word was written, bit 2 = default-type changed, and it is cleared at each start.
- R11: Every range write carries the full desired value, including bits outside the compare mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to apply the target configuration |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| chg_o | output | 3 | Change mask {default, fixed, variable} |
| cd_o | output | 1 | Cache disable |
| nw_o | output | 1 | No-write-through control, held 0 |
| wb_req_o | output | 1 | Write-back-and-invalidate request |
| wb_done_i | input | 1 | Write-back-and-invalidate finished |
| pge_i | input | 1 | Current global-page enable |
| pge_o | output | 1 | Global-page enable driven by the block |
| tlb_req_o | output | 1 | TLB flush request |
| tlb_done_i | input | 1 | TLB flush finished |
| reg_addr_o | output | AW | Register file address |
| reg_rdata_i | input | 64 | Current register value at `reg_addr_o` |
| tgt_rdata_i | input | 64 | Desired register value at `reg_addr_o` |
| reg_we_o | output | 1 | Register write strobe |
| reg_wdata_o | output | 64 | Register write data |

## Verification
The assertions check, on every cycle, the guards that hold whatever the data: a flush request appears only under cache disable, a TLB request only with global pages off, a write only inside that window, flush requests stay up until acknowledged, and `done_o` lasts one cycle with the cache re-enabled. The masked comparisons, the disabled-slot zeroing, the visiting order, the default-type merge and the change mask depend on the register contents. Only the bench's scenarios show these, through an independently built expected event list, write data and final register image.

// File: rtl/rus_pkg.sv
package rus_pkg;
    localparam int          FIX_WORDS     = 11;
    localparam logic [31:0] VBASE_LO_KEEP = 32'hFFFF_F0FF;
    localparam logic [31:0] VMASK_LO_KEEP = 32'hFFFF_F800;
    localparam logic [63:0] DEF_CTL_BITS  = 64'h0000_0000_0000_0CFF;
    localparam int          VLD_BIT       = 11;
    localparam int          CHG_W         = 3;
    localparam int          CHG_VAR       = 0;
    localparam int          CHG_FIX       = 1;
    localparam int          CHG_DEF       = 2;

    typedef enum logic [3:0] {
        S_IDLE, S_CD_ON, S_WBINV, S_PGE_OFF, S_TLB_IN, S_DEF_SAVE, S_DEF_CLR,
        S_SCAN, S_DEF_CMP, S_TLB_OUT, S_DEF_REST, S_CD_OFF, S_PGE_ON, S_DONE
    } seq_st_e;

    typedef enum logic [1:0] {RK_DEF, RK_VBASE, RK_VMASK, RK_FIX} reg_kind_e;
endpackage

// File: rtl/rus_hs.sv
module rus_hs (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    input  logic done_i,
    output logic req_o,
    output logic fin_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              req_o <= 1'b0;
        else if (go_i)           req_o <= 1'b1;
        else if (req_o && done_i) req_o <= 1'b0;
    end

    assign fin_o = req_o & done_i;

    // R2: a request stays up until its done arrives
    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !done_i) |=> req_o);
endmodule

// File: rtl/rus_cmp.sv
module rus_cmp
    import rus_pkg::*;
#(
    parameter int          NVAR       = 4,
    parameter int          AW         = 5,
    parameter logic [31:0] PA_HI_MASK = 32'h0000_000F
) (
    input  logic [AW-1:0] addr_i,
    input  logic [63:0]   cur_i,
    input  logic [63:0]   tgt_i,
    input  logic          slot_vld_i,
    output reg_kind_e     kind_o,
    output logic          diff_o,
    output logic [63:0]   want_o
);
    localparam int VAR_TOP = 2 * NVAR;

    logic [63:0] keep;

    always_comb begin
        if (addr_i == '0)                 kind_o = RK_DEF;
        else if (int'(addr_i) <= VAR_TOP) kind_o = addr_i[0] ? RK_VBASE : RK_VMASK;
        else                              kind_o = RK_FIX;
    end

    always_comb begin
        unique case (kind_o)
            RK_VMASK: begin
                keep   = {PA_HI_MASK, VMASK_LO_KEEP};
                want_o = tgt_i[VLD_BIT] ? tgt_i : '0;
            end
            RK_VBASE: begin
                keep   = {PA_HI_MASK, VBASE_LO_KEEP};
                want_o = slot_vld_i ? tgt_i : '0;
            end
            RK_FIX: begin
                keep   = '1;
                want_o = tgt_i;
            end
            default: begin
                keep   = DEF_CTL_BITS;
                want_o = tgt_i;
            end
        endcase
        diff_o = |((cur_i ^ want_o) & keep);
    end
endmodule

// File: rtl/rus_top.sv
module rus_top
    import rus_pkg::*;
#(
    parameter int          NVAR       = 4,
    parameter logic [31:0] PA_HI_MASK = 32'h0000_000F,
    parameter int          AW         = $clog2(2 * NVAR + FIX_WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [CHG_W-1:0] chg_o,
    output logic             cd_o,
    output logic             nw_o,
    output logic             wb_req_o,
    input  logic             wb_done_i,
    input  logic             pge_i,
    output logic             pge_o,
    output logic             tlb_req_o,
    input  logic             tlb_done_i,
    output logic [AW-1:0]    reg_addr_o,
    input  logic [63:0]      reg_rdata_i,
    input  logic [63:0]      tgt_rdata_i,
    output logic             reg_we_o,
    output logic [63:0]      reg_wdata_o
);
    localparam int NSCAN = 2 * NVAR + FIX_WORDS;
    localparam int SW    = $clog2(NSCAN + 1);

    seq_st_e          st, st_nx;
    logic [SW-1:0]    idx;
    logic [63:0]      def_sav;
    logic             pge_sav, pge_q, cd_q, vld_q;
    logic [CHG_W-1:0] chg_q;
    logic             wb_go, tlb_go, wb_fin, tlb_fin;
    logic [AW-1:0]    scan_addr;
    reg_kind_e        kind;
    logic             diff;
    logic [63:0]      want;
    logic             scan_last, def_diff;

    rus_hs u_wb  (.clk(clk), .rst_n(rst_n), .go_i(wb_go),  .done_i(wb_done_i),
                  .req_o(wb_req_o),  .fin_o(wb_fin));
    rus_hs u_tlb (.clk(clk), .rst_n(rst_n), .go_i(tlb_go), .done_i(tlb_done_i),
                  .req_o(tlb_req_o), .fin_o(tlb_fin));

    rus_cmp #(.NVAR(NVAR), .AW(AW), .PA_HI_MASK(PA_HI_MASK)) u_cmp (
        .addr_i(reg_addr_o), .cur_i(reg_rdata_i), .tgt_i(tgt_rdata_i),
        .slot_vld_i(vld_q), .kind_o(kind), .diff_o(diff), .want_o(want));

    always_comb begin
        if (idx < SW'(2 * NVAR)) scan_addr = idx[0] ? AW'(idx) : AW'(idx + SW'(2));
        else                     scan_addr = AW'(idx + SW'(1));
    end

    assign scan_last = (idx == SW'(NSCAN - 1));
    assign def_diff  = |((def_sav ^ tgt_rdata_i) & DEF_CTL_BITS);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:     if (start_i) st_nx = S_CD_ON;
            S_CD_ON:    st_nx = S_WBINV;
            S_WBINV:    if (wb_fin) st_nx = S_PGE_OFF;
            S_PGE_OFF:  st_nx = S_TLB_IN;
            S_TLB_IN:   if (tlb_fin) st_nx = S_DEF_SAVE;
            S_DEF_SAVE: st_nx = S_DEF_CLR;
            S_DEF_CLR:  st_nx = S_SCAN;
            S_SCAN:     if (scan_last) st_nx = S_DEF_CMP;
            S_DEF_CMP:  st_nx = S_TLB_OUT;
            S_TLB_OUT:  if (tlb_fin) st_nx = S_DEF_REST;
            S_DEF_REST: st_nx = S_CD_OFF;
            S_CD_OFF:   st_nx = S_PGE_ON;
            S_PGE_ON:   st_nx = S_DONE;
            S_DONE:     st_nx = S_IDLE;
            default:    st_nx = S_IDLE;
        endcase
    end

    // registered outputs and saved state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0; def_sav <= '0; pge_sav <= 1'b0; pge_q <= 1'b0;
            cd_q <= 1'b0; vld_q <= 1'b0; chg_q <= '0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    pge_q <= pge_i;
                    if (start_i) begin
                        cd_q  <= 1'b1;
                        chg_q <= '0;
                    end
                end
                S_PGE_OFF: begin
                    pge_sav <= pge_q;
                    pge_q   <= 1'b0;
                end
                S_DEF_SAVE: def_sav <= reg_rdata_i;
                S_DEF_CLR:  idx <= '0;
                S_SCAN: begin
                    idx <= idx + SW'(1);
                    if (kind == RK_VMASK) vld_q <= tgt_rdata_i[VLD_BIT];
                    if (diff) begin
                        if (kind == RK_FIX) chg_q[CHG_FIX] <= 1'b1;
                        else                chg_q[CHG_VAR] <= 1'b1;
                    end
                end
                S_DEF_CMP: if (def_diff) begin
                    def_sav <= (def_sav & ~DEF_CTL_BITS) | (tgt_rdata_i & DEF_CTL_BITS);
                    chg_q[CHG_DEF] <= 1'b1;
                end
                S_CD_OFF: cd_q  <= 1'b0;
                S_PGE_ON: pge_q <= pge_sav;
                default: ;
            endcase
        end
    end

    // combinational outputs
    always_comb begin
        wb_go       = (st == S_CD_ON);
        tlb_go      = (st == S_PGE_OFF) || (st == S_DEF_CMP);
        reg_addr_o  = (st == S_SCAN) ? scan_addr : '0;
        reg_we_o    = 1'b0;
        reg_wdata_o = '0;
        unique case (st)
            S_DEF_CLR:  begin reg_we_o = 1'b1; reg_wdata_o = def_sav & ~DEF_CTL_BITS; end
            S_DEF_REST: begin reg_we_o = 1'b1; reg_wdata_o = def_sav; end
            S_SCAN:     begin reg_we_o = diff; reg_wdata_o = want; end
            default: ;
        endcase
    end

    assign busy_o = (st != S_IDLE);
    assign done_o = (st == S_DONE);
    assign chg_o  = chg_q;
    assign cd_o   = cd_q;
    assign nw_o   = 1'b0;
    assign pge_o  = pge_q;

    // R2: cache flush only requested with the cache disabled
    a_r2_wb_under_cd: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req_o |-> cd_o);
    // R3: TLB flush only with global pages off and cache disabled
    a_r3_tlb_pge_off: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_req_o |-> (cd_o && !pge_o));
    // R5: register writes confined to the protected window
    a_r5_we_window: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> (cd_o && !pge_o && !wb_req_o));
    // R10: completion is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R9: at completion the cache is enabled and no flush is pending
    a_r9_exit_clean: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!cd_o && !wb_req_o && !tlb_req_o));
endmodule

// File: tb/tb_rus_top.sv
module tb_rus_top;
    import rus_pkg::*;

    localparam int          CLK_PERIOD = 10;
    localparam int          NVAR       = 4;
    localparam int          NSCAN      = 2 * NVAR + FIX_WORDS;
    localparam int          NREG       = NSCAN + 1;
    localparam int          AW         = $clog2(NREG);
    localparam int          NSLOT      = 1 << AW;
    localparam logic [31:0] HIM        = 32'h0000_000F;
    localparam int          DLY        = 3;
    localparam int          MAXC       = 50000;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, pge_i = 1'b0;
    logic busy, done, cd, nw, wb_req, tlb_req, pge_o, we;
    logic wb_done = 1'b0, tlb_done = 1'b0;
    logic [2:0] chg;
    logic [AW-1:0] addr;
    logic [63:0] rdata, tdata, wdata;
    logic [63:0] hw  [0:NSLOT-1];
    logic [63:0] tgt [0:NSLOT-1];
    logic [63:0] eh  [0:NSLOT-1];
    int wb_cnt = 0, tlb_cnt = 0, n_chk = 0, n_fail = 0, dn_cnt = 0;
    int aq[$], eq[$];
    logic [63:0] adq[$], edq[$];
    logic [2:0] exp_chg;
    logic p_cd = 0, p_wb = 0, p_pge = 0, p_tlb = 0;

    assign rdata = hw[addr];
    assign tdata = tgt[addr];

    rus_top #(.NVAR(NVAR), .PA_HI_MASK(HIM)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
        .chg_o(chg), .cd_o(cd), .nw_o(nw), .wb_req_o(wb_req), .wb_done_i(wb_done),
        .pge_i(pge_i), .pge_o(pge_o), .tlb_req_o(tlb_req), .tlb_done_i(tlb_done),
        .reg_addr_o(addr), .reg_rdata_i(rdata), .tgt_rdata_i(tdata),
        .reg_we_o(we), .reg_wdata_o(wdata));

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) if (rst_n && we) hw[addr] <= wdata;

    // handshake stubs
    always @(negedge clk) begin
        if (wb_req) begin wb_cnt <= wb_cnt + 1; wb_done <= (wb_cnt >= DLY); end
        else begin wb_cnt <= 0; wb_done <= 1'b0; end
        if (tlb_req) begin tlb_cnt <= tlb_cnt + 1; tlb_done <= (tlb_cnt >= DLY - 1); end
        else begin tlb_cnt <= 0; tlb_done <= 1'b0; end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // event monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (cd && !p_cd)       aq.push_back(1 * 256);
            if (wb_req && !p_wb)   aq.push_back(2 * 256);
            if (!pge_o && p_pge)   aq.push_back(3 * 256);
            if (tlb_req && !p_tlb) aq.push_back(4 * 256);
            if (we) begin
                aq.push_back(5 * 256 + int'(addr));
                adq.push_back(wdata);
                chk(cd && !pge_o, "R5 write window", {62'd0, cd, pge_o}, 64'h2);
            end
            if (!cd && p_cd)       aq.push_back(6 * 256);
            if (pge_o && !p_pge)   aq.push_back(7 * 256);
            if (done) begin aq.push_back(8 * 256); dn_cnt++; end
        end
        p_cd <= cd; p_wb <= wb_req; p_pge <= pge_o; p_tlb <= tlb_req;
    end

    function automatic string ev_tag(input int ev);
        int c = ev / 256, a = ev % 256;
        if (c <= 2) return "R2";
        if (c == 3) return "R3";
        if (c == 5 && a == 0) return "R4";
        if (c == 5 && a <= 2 * NVAR) return "R5";
        if (c == 5) return "R7";
        if (c == 8) return "R10";
        return "R9";
    endfunction

    // reference model: expected events, write data, final image, change mask
    task automatic build_exp(input bit pg);
        logic [63:0] sv, cur, w, k;
        int a;
        eq.delete(); edq.delete(); exp_chg = 3'b000;
        for (int i = 0; i < NSLOT; i++) eh[i] = hw[i];
        sv = eh[0];
        eq.push_back(256); eq.push_back(2 * 256);
        if (pg) eq.push_back(3 * 256);
        eq.push_back(4 * 256);
        eq.push_back(5 * 256); edq.push_back(sv & ~64'hCFF); eh[0] = sv & ~64'hCFF;
        for (int j = 0; j < NSCAN; j++) begin
            if (j < 2 * NVAR) begin
                a = (j % 2 == 1) ? j : j + 2;
                w = tgt[2 + 2 * (j / 2)][11] ? tgt[a] : 64'd0;
                k = {HIM, (j % 2 == 1) ? 32'hFFFF_F0FF : 32'hFFFF_F800};
            end else begin
                a = j + 1; w = tgt[a]; k = '1;
            end
            cur = eh[a];
            if (((cur ^ w) & k) != 0) begin
                eq.push_back(5 * 256 + a); edq.push_back(w); eh[a] = w;
                if (j < 2 * NVAR) exp_chg[0] = 1'b1; else exp_chg[1] = 1'b1;
            end
        end
        if (((sv ^ tgt[0]) & 64'hCFF) != 0) begin
            sv = (sv & ~64'hCFF) | (tgt[0] & 64'hCFF);
            exp_chg[2] = 1'b1;
        end
        eq.push_back(4 * 256);
        eq.push_back(5 * 256); edq.push_back(sv); eh[0] = sv;
        eq.push_back(6 * 256);
        if (pg) eq.push_back(7 * 256);
        eq.push_back(8 * 256);
    endtask

    task automatic run_seq(input bit pg, input bit poke, input string nm);
        logic [2:0] got;
        build_exp(pg);
        pge_i = pg;
        repeat (3) @(negedge clk);
        aq.delete(); adq.delete(); dn_cnt = 0;
        start = 1'b1; @(negedge clk); start = 1'b0;
        if (poke) begin
            repeat (5) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;
        end
        while (!done) @(negedge clk);
        got = chg;
        repeat (4) @(negedge clk);
        chk(got == exp_chg, {"R10 change mask ", nm}, {61'd0, got}, {61'd0, exp_chg});
        chk(dn_cnt == 1, {"R1 R10 done count ", nm}, dn_cnt, 1);
        chk(!busy, {"R1 idle after ", nm}, busy, 0);
        chk(aq.size() == eq.size(), {"R2 event count ", nm}, aq.size(), eq.size());
        if (aq.size() == eq.size())
            foreach (eq[i]) chk(aq[i] == eq[i], {ev_tag(eq[i]), " event ", nm}, aq[i], eq[i]);
        chk(adq.size() == edq.size(), {"R11 write count ", nm}, adq.size(), edq.size());
        if (adq.size() == edq.size())
            foreach (edq[i]) chk(adq[i] == edq[i], {"R11 write data ", nm}, adq[i], edq[i]);
        for (int i = 0; i < NREG; i++)
            chk(hw[i] == eh[i], i == 0 ? {"R8 final default ", nm} :
                (i <= 2 * NVAR ? {"R5 final var ", nm} : {"R7 final fixed ", nm}),
                hw[i], eh[i]);
    endtask

    initial begin
        repeat (MAXC) @(posedge clk);
        chk(1'b0, "R1 watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NSLOT; i++) hw[i] <= 64'h0;
        hw[0] <= 64'h0000_0001_0000_0C06;
        for (int s = 0; s < NVAR; s++) begin
            hw[1 + 2 * s] <= 64'h0000_0000_0000_0006 | (64'(s) << 28);
            hw[2 + 2 * s] <= 64'h0000_000F_F000_0800;
        end
        for (int f = 0; f < FIX_WORDS; f++) hw[2 * NVAR + 1 + f] <= {8{8'(f + 1)}};
        repeat (3) @(negedge clk);
        for (int i = 0; i < NSLOT; i++) tgt[i] = hw[i];
        // reset state
        chk(!busy && !done && !we, "R1 reset idle", {busy, done, we}, 0);
        chk(!cd && !nw && !wb_req && !tlb_req, "R1 reset controls",
            {cd, nw, wb_req, tlb_req}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !cd, "R1 idle after reset", {busy, cd}, 0);

        // scenario A: ignored bits, real changes, disabled slot, fixed, default
        tgt[1]  = hw[1] ^ 64'h8000_0F00_0000_0000 ^ 64'h0000_0000_0000_0F00;
        tgt[4]  = hw[4] ^ 64'h0000_0000_0000_07FF;
        tgt[5]  = hw[5] ^ 64'h0000_0000_0000_0001;
        tgt[6]  = hw[6] ^ 64'h0000_0003_0000_0000;
        tgt[8]  = 64'h0000_000F_FF00_0000;
        tgt[12] = hw[12] ^ 64'h0100_0000_0000_0000;
        tgt[19] = hw[19] ^ 64'h0000_0000_0000_0080;
        tgt[0]  = 64'h0000_0000_0000_0C00;
        run_seq(1'b1, 1'b0, "A");
        chk(hw[7] == 0 && hw[8] == 0, "R6 disabled slot zeroed", hw[8], 0);
        chk(hw[0][32], "R4 saved upper bits kept", hw[0], 64'h0000_0001_0000_0C00);

        // scenario B: nothing to change, start poked while busy, pages off
        for (int i = 0; i < NSLOT; i++) tgt[i] = hw[i];
        run_seq(1'b0, 1'b1, "B");

        // scenario C: re-enable slot, only default enable bit changes
        tgt[7] = 64'h0000_0002_4000_0005;
        tgt[8] = 64'h0000_000F_C000_0800;
        tgt[0] = hw[0] ^ 64'h0000_0000_0000_0400;
        run_seq(1'b1, 1'b0, "C");
        chk(hw[8] == tgt[8], "R6 slot enabled", hw[8], tgt[8]);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule